// File: doc/BRIEF.md
# Sequencer Register Bank with FIFO Interrupts

This block is the memory-mapped front end of a serial-bus command sequencer. A host writes commands and transmit bytes through a simple strobe port. The block stores them in two FIFOs that the sequencer drains. Received bytes that the sequencer pushes collect in a third FIFO. The host removes them with a pop read, or looks at the oldest one with a peek read that leaves it in place. The host can also read how much room each outbound FIFO has and how full the inbound one is.

Four interrupt sources feed a single interrupt line. Three of them are levels that follow the fill of the FIFOs: the command queue is nearly empty, the transmit queue is nearly empty, or the receive queue is nearly full. The fourth is a sticky sync event. When the sequencer reports a sync, the event also stores an 8-bit tag, and the host clears the event by writing a one to it. A control register holds the sequencer in reset, and while it does, all three FIFOs are emptied.

Top module: `seq_regbank`

## Requirements
- R1: A read of offset 0x00 returns the major version 1 in bits [23:16], the minor version in bits [15:8] and the patch level in bits [7:0]. Bits [31:24] read as 0.
- R2: Offset 0x40 bit 0 drives `eng_rst`. It is 1 after reset and reads back as written. While it is 1, all three FIFOs are held empty and every push is ignored.
- R3: Offset 0xD0 reads the free entries of the command FIFO. Offset 0xD4 reads the free entries of the transmit FIFO. Offset 0xD8 reads the number of entries in the receive FIFO.
- R4: A write to 0xE0 pushes wdata[15:0] as a command, and a write to 0xE4 pushes wdata[7:0] as a transmit byte. Each FIFO presents its entries in first-in first-out order on `cmd_data` or `tx_data`. A push into a full FIFO is ignored.
- R5: A read of 0xE8 returns the oldest receive byte in bits [7:0] and removes it. On an empty receive FIFO the read returns 0 and the level stays 0.
- R6: A read of 0xEC returns the oldest receive byte and does not remove it.
- R7: Pending bit 0 is 1 while the command FIFO holds at most DEPTH/4 entries. Bit 1 is the same for the transmit FIFO. Bit 2 is 1 while the receive FIFO holds at least 3*DEPTH/4 entries. These bits follow the levels, and a write to the pending register has no effect on them.
- R8: A pulse on `sync_strobe` stores `sync_id`, which reads back at 0xC0, and sets pending bit 3. Writing 1 to bit 3 of offset 0x84 clears it. If a sync pulse and that clearing write come in the same cycle, the bit stays set.
- R9: Offset 0x80 bits [3:0] hold the interrupt enables. Offset 0x88 reads pending AND enable. `irq` is the OR of those bits and follows one clock after them.
- R10: Read data is registered and appears on `bus_rdata` in the cycle after `bus_rd`. An unmapped offset reads 0. Offset 0x84 reads the pending bits in [3:0].
- R11: A `cmd_pop` or `tx_pop` on an empty FIFO is ignored. `rx_ready` is low while the receive FIFO is full, and an `rx_push` in that state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cmd_valid | output | 1 | Command FIFO not empty |
| cmd_data | output | CMD_W | Oldest command |
| cmd_pop | input | 1 | Sequencer takes a command |
| tx_valid | output | 1 | Transmit FIFO not empty |
| tx_data | output | DAT_W | Oldest transmit byte |
| tx_pop | input | 1 | Sequencer takes a transmit byte |
| rx_ready | output | 1 | Receive FIFO has room |
| rx_data | input | DAT_W | Received byte |
| rx_push | input | 1 | Sequencer stores a received byte |
| sync_strobe | input | 1 | Sync event pulse |
| sync_id | input | 8 | Tag of the sync event |
| eng_rst | output | 1 | Holds the sequencer in reset |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills each FIFO one entry past full. After every push it compares the room or level count and the threshold bits with values it works out itself. A design with a threshold one entry off, or one that wrapped a pointer on overflow, would report a wrong count or deliver entries out of order. The bench peeks twice before popping, and pops an empty receive FIFO, to catch a peek that removes data or an empty pop that underflows the level. It issues a sync pulse in the same cycle as its clearing write, and it sweeps all sixteen enable masks. A design that let the clear win, or that decoded the source register from the wrong bits, would then read the wrong value or raise the interrupt line wrongly.

// File: rtl/seq_regbank_pkg.sv
package seq_regbank_pkg;
  localparam int BUS_W = 32;
  localparam int NIRQ  = 4;

  localparam logic [7:0] OFF_VERSION = 8'h00;
  localparam logic [7:0] OFF_ENGRST  = 8'h40;
  localparam logic [7:0] OFF_IRQ_EN  = 8'h80;
  localparam logic [7:0] OFF_IRQ_PND = 8'h84;
  localparam logic [7:0] OFF_IRQ_SRC = 8'h88;
  localparam logic [7:0] OFF_SYNCID  = 8'hC0;
  localparam logic [7:0] OFF_CMD_RM  = 8'hD0;
  localparam logic [7:0] OFF_TX_RM   = 8'hD4;
  localparam logic [7:0] OFF_RX_LVL  = 8'hD8;
  localparam logic [7:0] OFF_CMD_PSH = 8'hE0;
  localparam logic [7:0] OFF_TX_PSH  = 8'hE4;
  localparam logic [7:0] OFF_RX_POP  = 8'hE8;
  localparam logic [7:0] OFF_RX_PEEK = 8'hEC;

  localparam int IB_CMD_LOW = 0;
  localparam int IB_TX_LOW  = 1;
  localparam int IB_RX_HIGH = 2;
  localparam int IB_SYNC    = 3;

  localparam logic [7:0] VER_MAJOR = 8'd1;
endpackage

// File: rtl/seq_regbank_fifo.sv
module seq_regbank_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign head    = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/seq_regbank_irq.sv
module seq_regbank_irq
  import seq_regbank_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(DEPTH+1)-1:0] cmd_lvl,
  input  logic [$clog2(DEPTH+1)-1:0] tx_lvl,
  input  logic [$clog2(DEPTH+1)-1:0] rx_lvl,
  input  logic                       sync_set,
  input  logic                       clr_wr,
  input  logic [NIRQ-1:0]            clr_bits,
  input  logic [NIRQ-1:0]            en,
  output logic [NIRQ-1:0]            pend,
  output logic [NIRQ-1:0]            src,
  output logic                       irq
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] LOW_LIM  = CW'(DEPTH/4);
  localparam logic [CW-1:0] HIGH_LIM = CW'((3*DEPTH)/4);

  logic sync_pend;

  always_ff @(posedge clk) begin
    if (rst)                           sync_pend <= 1'b0;
    else if (sync_set)                 sync_pend <= 1'b1;
    else if (clr_wr && clr_bits[IB_SYNC]) sync_pend <= 1'b0;
  end

  always_comb begin
    pend             = '0;
    pend[IB_CMD_LOW] = (cmd_lvl <= LOW_LIM);
    pend[IB_TX_LOW]  = (tx_lvl  <= LOW_LIM);
    pend[IB_RX_HIGH] = (rx_lvl  >= HIGH_LIM);
    pend[IB_SYNC]    = sync_pend;
  end

  assign src = pend & en;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |src;
  end
endmodule

// File: rtl/seq_regbank.sv
module seq_regbank
  import seq_regbank_pkg::*;
#(
  parameter int         DEPTH     = 16,
  parameter int         CMD_W     = 16,
  parameter int         DAT_W     = 8,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] VER_MINOR = 8'd0,
  parameter logic [7:0] VER_PATCH = 8'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_data,
  input  logic              cmd_pop,
  output logic              tx_valid,
  output logic [DAT_W-1:0]  tx_data,
  input  logic              tx_pop,
  output logic              rx_ready,
  input  logic [DAT_W-1:0]  rx_data,
  input  logic              rx_push,
  input  logic              sync_strobe,
  input  logic [7:0]        sync_id,
  output logic              eng_rst,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic          eng_rst_q;
  logic [NIRQ-1:0] int_en;
  logic [7:0]    sync_id_q;
  logic          fifo_clr;

  logic          sel_ver, sel_rst, sel_en, sel_pnd, sel_src, sel_sid;
  logic          sel_crm, sel_trm, sel_rlv, sel_cps, sel_tps, sel_pop, sel_pk;

  logic          cmd_push, tx_push, rx_pop;
  logic [CW-1:0] cmd_lvl, tx_lvl, rx_lvl;
  logic          cmd_full, cmd_empty, tx_full, tx_empty, rx_full, rx_empty;
  logic [DAT_W-1:0] rx_head;
  logic [NIRQ-1:0]  pend, src;

  assign sel_ver = (bus_addr == ADDR_W'(OFF_VERSION));
  assign sel_rst = (bus_addr == ADDR_W'(OFF_ENGRST));
  assign sel_en  = (bus_addr == ADDR_W'(OFF_IRQ_EN));
  assign sel_pnd = (bus_addr == ADDR_W'(OFF_IRQ_PND));
  assign sel_src = (bus_addr == ADDR_W'(OFF_IRQ_SRC));
  assign sel_sid = (bus_addr == ADDR_W'(OFF_SYNCID));
  assign sel_crm = (bus_addr == ADDR_W'(OFF_CMD_RM));
  assign sel_trm = (bus_addr == ADDR_W'(OFF_TX_RM));
  assign sel_rlv = (bus_addr == ADDR_W'(OFF_RX_LVL));
  assign sel_cps = (bus_addr == ADDR_W'(OFF_CMD_PSH));
  assign sel_tps = (bus_addr == ADDR_W'(OFF_TX_PSH));
  assign sel_pop = (bus_addr == ADDR_W'(OFF_RX_POP));
  assign sel_pk  = (bus_addr == ADDR_W'(OFF_RX_PEEK));

  assign fifo_clr = rst || eng_rst_q;
  assign cmd_push = bus_wr && sel_cps;
  assign tx_push  = bus_wr && sel_tps;
  assign rx_pop   = bus_rd && sel_pop;

  // Control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      eng_rst_q <= 1'b1;
      int_en    <= '0;
    end else if (bus_wr) begin
      if (sel_rst) eng_rst_q <= bus_wdata[0];
      if (sel_en)  int_en    <= bus_wdata[NIRQ-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              sync_id_q <= '0;
    else if (sync_strobe) sync_id_q <= sync_id;
  end

  assign eng_rst = eng_rst_q;

  // Storage
  seq_regbank_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_cmd_fifo (
    .clk(clk), .clr(fifo_clr), .push(cmd_push), .din(bus_wdata[CMD_W-1:0]),
    .pop(cmd_pop), .head(cmd_data), .count(cmd_lvl), .full(cmd_full), .empty(cmd_empty)
  );

  seq_regbank_fifo #(.W(DAT_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .clr(fifo_clr), .push(tx_push), .din(bus_wdata[DAT_W-1:0]),
    .pop(tx_pop), .head(tx_data), .count(tx_lvl), .full(tx_full), .empty(tx_empty)
  );

  seq_regbank_fifo #(.W(DAT_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .clr(fifo_clr), .push(rx_push), .din(rx_data),
    .pop(rx_pop), .head(rx_head), .count(rx_lvl), .full(rx_full), .empty(rx_empty)
  );

  assign cmd_valid = !cmd_empty;
  assign tx_valid  = !tx_empty;
  assign rx_ready  = !rx_full;

  // Interrupts
  seq_regbank_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst(rst),
    .cmd_lvl(cmd_lvl), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
    .sync_set(sync_strobe),
    .clr_wr(bus_wr && sel_pnd), .clr_bits(bus_wdata[NIRQ-1:0]),
    .en(int_en), .pend(pend), .src(src), .irq(irq)
  );

  // Registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (sel_ver) bus_rdata <= {8'h00, VER_MAJOR, VER_MINOR, VER_PATCH};
      if (sel_rst) bus_rdata <= BUS_W'(eng_rst_q);
      if (sel_en)  bus_rdata <= BUS_W'(int_en);
      if (sel_pnd) bus_rdata <= BUS_W'(pend);
      if (sel_src) bus_rdata <= BUS_W'(src);
      if (sel_sid) bus_rdata <= BUS_W'(sync_id_q);
      if (sel_crm) bus_rdata <= BUS_W'(DEPTH_C - cmd_lvl);
      if (sel_trm) bus_rdata <= BUS_W'(DEPTH_C - tx_lvl);
      if (sel_rlv) bus_rdata <= BUS_W'(rx_lvl);
      if ((sel_pop || sel_pk) && !rx_empty) bus_rdata <= BUS_W'(rx_head);
    end
  end
endmodule

// File: rtl/seq_regbank_chk.sv
module seq_regbank_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       eng_rst,
  input logic                       rx_push,
  input logic                       rx_pop,
  input logic                       rx_ready,
  input logic [$clog2(DEPTH+1)-1:0] rx_lvl,
  input logic                       sync_strobe,
  input logic [7:0]                 sync_id,
  input logic [7:0]                 sync_id_q,
  input logic [3:0]                 pend,
  input logic [3:0]                 int_en,
  input logic                       irq
);
  // R11
  rx_full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_push && !rx_ready && !rx_pop && !eng_rst) |=> (rx_lvl == $past(rx_lvl)));

  // R8
  sync_latch_chk: assert property (@(posedge clk) disable iff (rst)
    sync_strobe |=> (pend[3] && (sync_id_q == $past(sync_id))));

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (int_en == 4'b0000) |=> !irq);

  // R2
  soft_flush_chk: assert property (@(posedge clk) disable iff (rst)
    eng_rst |=> (rx_lvl == '0));

  // R7
  rx_high_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_lvl >= ($clog2(DEPTH+1))'((3*DEPTH)/4)) |-> pend[2]);
endmodule

bind seq_regbank seq_regbank_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .eng_rst(eng_rst), .rx_push(rx_push), .rx_pop(rx_pop),
  .rx_ready(rx_ready), .rx_lvl(rx_lvl), .sync_strobe(sync_strobe), .sync_id(sync_id),
  .sync_id_q(sync_id_q), .pend(pend), .int_en(int_en), .irq(irq)
);

// File: tb/seq_regbank_bench.sv
`timescale 1ns/1ps
module seq_regbank_bench;
  localparam int D = 8;
  localparam logic [7:0] MINV = 8'h02;
  localparam logic [7:0] PATV = 8'h05;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        cmd_valid, tx_valid, rx_ready, eng_rst, irq;
  logic [15:0] cmd_data;
  logic [7:0]  tx_data;
  logic        cmd_pop = 0, tx_pop = 0, rx_push = 0, sync_strobe = 0;
  logic [7:0]  rx_data = 0, sync_id = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  seq_regbank #(.DEPTH(D), .VER_MINOR(MINV), .VER_PATCH(PATV)) u_seq_regbank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .cmd_pop(cmd_pop), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_ready(rx_ready), .rx_data(rx_data), .rx_push(rx_push),
    .sync_strobe(sync_strobe), .sync_id(sync_id), .eng_rst(eng_rst), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask

  task automatic pulse_cmd_pop();
    @(negedge clk); cmd_pop = 1; @(negedge clk); cmd_pop = 0;
  endtask

  task automatic pulse_tx_pop();
    @(negedge clk); tx_pop = 1; @(negedge clk); tx_pop = 0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); rx_push = 1; rx_data = b; @(negedge clk); rx_push = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // Reset state
    chk("R9 irq after reset", irq, 0);
    rd(8'h00, v); chk("R1 version", v, {8'h00, 8'h01, MINV, PATV});
    rd(8'h40, v); chk("R2 engine reset default", v, 1);
    chk("R2 eng_rst pin", eng_rst, 1);
    rd(8'h84, v); chk("R10 pending after reset", v, 32'h3);
    rd(8'h80, v); chk("R9 enable after reset", v, 0);
    rd(8'hD0, v); chk("R3 cmd room after reset", v, D);
    chk("R11 cmd_valid after reset", cmd_valid, 0);

    // R2: push ignored while held
    wr(8'hE4, 32'hAA);
    rd(8'hD4, v); chk("R2 push ignored in soft reset", v, D);
    wr(8'h40, 0);
    rd(8'h40, v); chk("R2 engine released", v, 0);

    // Command FIFO sweep
    for (int k = 1; k <= D + 2; k++) begin
      int lvl;
      lvl = (k < D) ? k : D;
      wr(8'hE0, 32'hFFFF_0000 | (32'h1000 + k));
      rd(8'hD0, v); chk("R3 cmd room", v, D - lvl);
      rd(8'h84, v); chk("R7 cmd low bit", v[0], (lvl <= D/4) ? 1 : 0);
    end
    for (int k = 1; k <= D; k++) begin
      chk("R4 cmd_valid", cmd_valid, 1);
      chk("R4 cmd order", cmd_data, 16'h1000 + k);
      pulse_cmd_pop();
    end
    chk("R11 cmd empty", cmd_valid, 0);
    pulse_cmd_pop();
    rd(8'hD0, v); chk("R11 cmd pop on empty", v, D);

    // Transmit FIFO sweep
    for (int k = 1; k <= D + 1; k++) begin
      int lvl;
      lvl = (k < D) ? k : D;
      wr(8'hE4, 32'h0000_0100 | (k * 3));
      rd(8'hD4, v); chk("R3 tx room", v, D - lvl);
      rd(8'h84, v); chk("R7 tx low bit", v[1], (lvl <= D/4) ? 1 : 0);
    end
    for (int k = 1; k <= D; k++) begin
      chk("R4 tx order", tx_data, (k * 3) & 8'hFF);
      pulse_tx_pop();
    end
    chk("R11 tx empty", tx_valid, 0);
    pulse_tx_pop();
    rd(8'hD4, v); chk("R11 tx pop on empty", v, D);

    // Receive FIFO sweep
    for (int k = 1; k <= D + 1; k++) begin
      int lvl;
      lvl = (k < D) ? k : D;
      chk("R11 rx_ready", rx_ready, (k <= D) ? 1 : 0);
      push_rx(8'h40 + k);
      rd(8'hD8, v); chk("R3 rx level", v, lvl);
      rd(8'h84, v); chk("R7 rx high bit", v[2], (lvl >= (3*D)/4) ? 1 : 0);
    end
    wr(8'h84, 32'h7);
    rd(8'h84, v); chk("R7 level bits ignore clear", v, 32'h4 | 32'h3);
    rd(8'hEC, v); chk("R6 peek", v, 8'h41);
    rd(8'hEC, v); chk("R6 peek repeat", v, 8'h41);
    rd(8'hD8, v); chk("R6 level after peek", v, D);
    for (int k = 1; k <= D; k++) begin
      rd(8'hE8, v); chk("R5 pop order", v, 8'h40 + k);
    end
    rd(8'hE8, v); chk("R5 pop empty data", v, 0);
    rd(8'hD8, v); chk("R5 pop empty level", v, 0);
    rd(8'h44, v); chk("R10 unmapped", v, 0);

    // Sync event
    @(negedge clk); sync_strobe = 1; sync_id = 8'h5A;
    @(negedge clk); sync_strobe = 0;
    rd(8'hC0, v); chk("R8 sync id", v, 8'h5A);
    rd(8'h84, v); chk("R8 sync set", v[3], 1);
    wr(8'h84, 32'h8);
    rd(8'h84, v); chk("R8 sync cleared", v[3], 0);
    @(negedge clk); bus_wr = 1; bus_addr = 8'h84; bus_wdata = 32'h8;
    sync_strobe = 1; sync_id = 8'h77;
    @(negedge clk); bus_wr = 0; sync_strobe = 0;
    rd(8'h84, v); chk("R8 set beats clear", v[3], 1);
    rd(8'hC0, v); chk("R8 sync id update", v, 8'h77);

    // Enable sweep: pending is cmd low, tx low, sync => 0xB
    for (int en = 0; en < 16; en++) begin
      wr(8'h80, en);
      @(negedge clk);
      chk("R9 irq", irq, ((en & 4'hB) != 0) ? 1 : 0);
      rd(8'h88, v); chk("R9 source", v, en & 4'hB);
    end
    rd(8'h80, v); chk("R9 enable readback", v, 15);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule